// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block holds the hazard logic of a five-stage in-order pipeline. It looks at the register indices and control bits held in the execute, memory and write-back stage registers, at the two source fields of the instruction being decoded, and at the branch outcome found in execute. From these it produces the selects and enables that the datapath uses to stay correct without software help.

It has three jobs. The first is to pick an operand source for each ALU input, and when two older instructions both write the register, the nearer one wins. The second is to hold fetch and decode for one cycle and put a bubble into execute when a load's result is needed at once. The third is to squash the two younger instructions when a branch is taken.

A further path covers a store that directly follows a load of its own data register. In that case the loaded value is steered to the data-memory write port. The stage fields are captured in a bank of registers inside the block, and every output is a combinational function of that captured state. An output therefore shows the fields that were presented at the previous rising clock edge.

Top module: `hzc_top`

## Requirements
- R1: For each ALU operand, the select is 2'b10 when the memory-stage instruction writes a register (write enable high) whose index equals that execute-stage source index. Otherwise it is 2'b01 when the write-back-stage instruction writes a register equal to that source. Otherwise it is 2'b00. Operand A uses the execute rs1 field and operand B the execute rs2 field, each on its own.
- R2: When the memory stage and the write-back stage both write the register that a source names, that operand's select is 2'b10.
- R3: A destination index of 0, or a write enable that is low, never produces a forwarding select other than 2'b00 for that producing stage.
- R4: A load-use hazard exists when the execute-stage instruction has its memory-read bit and write enable high and a destination other than 0 that equals the decode rs1 or rs2 field. When it exists and no branch is taken, pc_we and ifid_we are both 0. Otherwise both are 1.
- R5: bubble_sel is 1 exactly in the cycles in which the stall of R4 is applied, and 0 in all other cycles.
- R6: flush is 1 exactly when the captured branch-taken bit is 1.
- R7: When a branch is taken and a load-use hazard is present together, flush is 1, pc_we and ifid_we are 1, and bubble_sel is 0.
- R8: st_data_sel is 1 when all of the following hold: the memory-stage instruction is a store; the write-back stage holds a load (write enable and memory-to-register bits both high) with a destination other than 0; and the store's rs2 equals that destination.
- R9: st_data_sel is 0 when the write-back instruction is not a load, when its destination is 0, or when the memory-stage instruction is not a store.
- R10: Outputs reflect the stage fields captured at the previous rising clock edge. While rst is high at an edge, the captured state clears. After that edge the outputs are fwd_a = fwd_b = 2'b00, st_data_sel = 0, pc_we = ifid_we = 1, bubble_sel = 0 and flush = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stage fields are captured on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the captured fields |
| in_dec_rs1 | input | 5 | First source index of the instruction in decode |
| in_dec_rs2 | input | 5 | Second source index of the instruction in decode |
| in_ex_rs1 | input | 5 | First source index of the instruction in execute |
| in_ex_rs2 | input | 5 | Second source index of the instruction in execute |
| in_ex_rd | input | 5 | Destination index of the instruction in execute |
| in_ex_reg_write | input | 1 | Execute instruction writes a register |
| in_ex_mem_read | input | 1 | Execute instruction is a load |
| in_mem_rd | input | 5 | Destination index of the memory-stage instruction |
| in_mem_rs2 | input | 5 | Store-data source index of the memory-stage instruction |
| in_mem_reg_write | input | 1 | Memory-stage instruction writes a register |
| in_mem_mem_write | input | 1 | Memory-stage instruction is a store |
| in_wb_rd | input | 5 | Destination index of the write-back instruction |
| in_wb_reg_write | input | 1 | Write-back instruction writes a register |
| in_wb_mem_to_reg | input | 1 | Write-back value comes from data memory (load) |
| in_branch_taken | input | 1 | Branch resolved taken in execute |
| fwd_a | output | 2 | Operand A source select |
| fwd_b | output | 2 | Operand B source select |
| st_data_sel | output | 1 | Use the loaded write-back value as store data |
| pc_we | output | 1 | PC write enable |
| ifid_we | output | 1 | IF/ID register write enable |
| bubble_sel | output | 1 | Zero the control fields entering ID/EX |
| flush | output | 1 | Clear the IF/ID and ID/EX registers |

## Verification
Each output comes from one small piece of logic over captured state. A wrong captured field, or a wrong priority, therefore shows up on the very next sample after the edge that captured it, with no hidden delay. A swapped priority only shows when both older stages hit the same source, so those vectors are driven on purpose. A lost x0 or write-enable guard shows as a non-zero select or a stall for a vector that should be quiet. A stall that wins over a flush shows as low write enables next to a high flush. Random fields drawn from a small index range make matches frequent, and directed vectors pin down each corner.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

    localparam int unsigned REG_AW  = 5;
    localparam int unsigned NUM_SRC = 2;

    typedef logic [REG_AW-1:0] ridx_t;

    typedef enum logic [1:0] {
        FWD_REGFILE  = 2'b00,
        FWD_FROM_WB  = 2'b01,
        FWD_FROM_MEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        ridx_t rs1;
        ridx_t rs2;
    } dec_fields_t;

    typedef struct packed {
        ridx_t rs1;
        ridx_t rs2;
        ridx_t rd;
        logic  reg_write;
        logic  mem_read;
    } ex_fields_t;

    typedef struct packed {
        ridx_t rd;
        ridx_t rs2;
        logic  reg_write;
        logic  mem_write;
    } mem_fields_t;

    typedef struct packed {
        ridx_t rd;
        logic  reg_write;
        logic  mem_to_reg;
    } wb_fields_t;

    // A stage really produces a value only if it writes a non-zero register.
    function automatic logic produces(ridx_t rd, logic we);
        return we && (rd != '0);
    endfunction

    function automatic logic hits(ridx_t rd, logic we, ridx_t src);
        return produces(rd, we) && (rd == src);
    endfunction

endpackage

// File: rtl/hzc_stage_regs.sv
module hzc_stage_regs
    import hzc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  dec_fields_t dec_d,
    input  ex_fields_t  ex_d,
    input  mem_fields_t mem_d,
    input  wb_fields_t  wb_d,
    input  logic        br_d,
    output dec_fields_t dec_q,
    output ex_fields_t  ex_q,
    output mem_fields_t mem_q,
    output wb_fields_t  wb_q,
    output logic        br_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= '0;
            ex_q  <= '0;
            mem_q <= '0;
            wb_q  <= '0;
            br_q  <= 1'b0;
        end else begin
            dec_q <= dec_d;
            ex_q  <= ex_d;
            mem_q <= mem_d;
            wb_q  <= wb_d;
            br_q  <= br_d;
        end
    end

endmodule

// File: rtl/hzc_operand_fwd.sv
module hzc_operand_fwd
    import hzc_pkg::*;
#(
    parameter int unsigned NSRC = NUM_SRC
) (
    input  ridx_t    src     [NSRC],
    input  ridx_t    mem_rd,
    input  logic     mem_we,
    input  ridx_t    wb_rd,
    input  logic     wb_we,
    output fwd_sel_e sel     [NSRC]
);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic near_hit;
        logic far_hit;

        assign near_hit = hits(mem_rd, mem_we, src[i]);
        assign far_hit  = hits(wb_rd, wb_we, src[i]);

        // The nearer (memory-stage) producer holds the newer value.
        always_comb begin
            if (near_hit)     sel[i] = FWD_FROM_MEM;
            else if (far_hit) sel[i] = FWD_FROM_WB;
            else              sel[i] = FWD_REGFILE;
        end
    end

endmodule

// File: rtl/hzc_stall_flush.sv
module hzc_stall_flush
    import hzc_pkg::*;
#(
    parameter int unsigned NSRC = NUM_SRC
) (
    input  ridx_t dec_src [NSRC],
    input  ridx_t ex_rd,
    input  logic  ex_we,
    input  logic  ex_load,
    input  logic  branch_taken,
    output logic  pc_we,
    output logic  ifid_we,
    output logic  bubble_sel,
    output logic  flush
);

    logic [NSRC-1:0] src_hit;
    logic            load_use;
    logic            stall;

    for (genvar i = 0; i < NSRC; i++) begin : g_cmp
        assign src_hit[i] = hits(ex_rd, ex_we, dec_src[i]);
    end

    assign load_use = ex_load && (|src_hit);

    // A taken branch squashes the decode instruction, so its hazard is moot.
    assign stall      = load_use && !branch_taken;
    assign flush      = branch_taken;
    assign pc_we      = !stall;
    assign ifid_we    = !stall;
    assign bubble_sel = stall;

endmodule

// File: rtl/hzc_store_bypass.sv
module hzc_store_bypass
    import hzc_pkg::*;
(
    input  logic  mem_store,
    input  ridx_t mem_rs2,
    input  ridx_t wb_rd,
    input  logic  wb_we,
    input  logic  wb_is_load,
    output logic  st_data_sel
);

    assign st_data_sel = mem_store && wb_is_load && hits(wb_rd, wb_we, mem_rs2);

endmodule

// File: rtl/hzc_top.sv
module hzc_top
    import hzc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] in_dec_rs1,
    input  logic [REG_AW-1:0] in_dec_rs2,
    input  logic [REG_AW-1:0] in_ex_rs1,
    input  logic [REG_AW-1:0] in_ex_rs2,
    input  logic [REG_AW-1:0] in_ex_rd,
    input  logic              in_ex_reg_write,
    input  logic              in_ex_mem_read,
    input  logic [REG_AW-1:0] in_mem_rd,
    input  logic [REG_AW-1:0] in_mem_rs2,
    input  logic              in_mem_reg_write,
    input  logic              in_mem_mem_write,
    input  logic [REG_AW-1:0] in_wb_rd,
    input  logic              in_wb_reg_write,
    input  logic              in_wb_mem_to_reg,
    input  logic              in_branch_taken,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b,
    output logic              st_data_sel,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              bubble_sel,
    output logic              flush
);

    dec_fields_t dec_d, dec_q;
    ex_fields_t  ex_d,  ex_q;
    mem_fields_t mem_d, mem_q;
    wb_fields_t  wb_d,  wb_q;
    logic        br_q;

    assign dec_d = '{rs1: in_dec_rs1, rs2: in_dec_rs2};
    assign ex_d  = '{rs1: in_ex_rs1, rs2: in_ex_rs2, rd: in_ex_rd,
                     reg_write: in_ex_reg_write, mem_read: in_ex_mem_read};
    assign mem_d = '{rd: in_mem_rd, rs2: in_mem_rs2,
                     reg_write: in_mem_reg_write, mem_write: in_mem_mem_write};
    assign wb_d  = '{rd: in_wb_rd, reg_write: in_wb_reg_write,
                     mem_to_reg: in_wb_mem_to_reg};

    hzc_stage_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .dec_d (dec_d),
        .ex_d  (ex_d),
        .mem_d (mem_d),
        .wb_d  (wb_d),
        .br_d  (in_branch_taken),
        .dec_q (dec_q),
        .ex_q  (ex_q),
        .mem_q (mem_q),
        .wb_q  (wb_q),
        .br_q  (br_q)
    );

    ridx_t    ex_src  [NUM_SRC];
    ridx_t    dec_src [NUM_SRC];
    fwd_sel_e op_sel  [NUM_SRC];

    assign ex_src[0]  = ex_q.rs1;
    assign ex_src[1]  = ex_q.rs2;
    assign dec_src[0] = dec_q.rs1;
    assign dec_src[1] = dec_q.rs2;

    hzc_operand_fwd #(.NSRC(NUM_SRC)) u_fwd (
        .src    (ex_src),
        .mem_rd (mem_q.rd),
        .mem_we (mem_q.reg_write),
        .wb_rd  (wb_q.rd),
        .wb_we  (wb_q.reg_write),
        .sel    (op_sel)
    );

    assign fwd_a = op_sel[0];
    assign fwd_b = op_sel[1];

    hzc_stall_flush #(.NSRC(NUM_SRC)) u_stall (
        .dec_src      (dec_src),
        .ex_rd        (ex_q.rd),
        .ex_we        (ex_q.reg_write),
        .ex_load      (ex_q.mem_read),
        .branch_taken (br_q),
        .pc_we        (pc_we),
        .ifid_we      (ifid_we),
        .bubble_sel   (bubble_sel),
        .flush        (flush)
    );

    hzc_store_bypass u_stbyp (
        .mem_store   (mem_q.mem_write),
        .mem_rs2     (mem_q.rs2),
        .wb_rd       (wb_q.rd),
        .wb_we       (wb_q.reg_write),
        .wb_is_load  (wb_q.mem_to_reg),
        .st_data_sel (st_data_sel)
    );

endmodule

// File: rtl/hzc_checker.sv
module hzc_checker
    import hzc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [REG_AW-1:0] in_dec_rs1,
    input logic [REG_AW-1:0] in_dec_rs2,
    input logic [REG_AW-1:0] in_ex_rs1,
    input logic [REG_AW-1:0] in_ex_rs2,
    input logic [REG_AW-1:0] in_ex_rd,
    input logic              in_ex_reg_write,
    input logic              in_ex_mem_read,
    input logic [REG_AW-1:0] in_mem_rd,
    input logic [REG_AW-1:0] in_mem_rs2,
    input logic              in_mem_reg_write,
    input logic              in_mem_mem_write,
    input logic [REG_AW-1:0] in_wb_rd,
    input logic              in_wb_reg_write,
    input logic              in_wb_mem_to_reg,
    input logic              in_branch_taken,
    input logic [1:0]        fwd_a,
    input logic [1:0]        fwd_b,
    input logic              st_data_sel,
    input logic              pc_we,
    input logic              ifid_we,
    input logic              bubble_sel,
    input logic              flush
);

    AST_FWD_A_NEAR: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_mem_reg_write && (in_mem_rd != '0) && (in_mem_rd == in_ex_rs1)))
        |-> (fwd_a == 2'b10)); // R2

    AST_FWD_B_NEAR: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_mem_reg_write && (in_mem_rd != '0) && (in_mem_rd == in_ex_rs2)))
        |-> (fwd_b == 2'b10)); // R1

    AST_X0_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past((in_mem_rd == '0) && (in_wb_rd == '0)))
        |-> (fwd_a == 2'b00 && fwd_b == 2'b00)); // R3

    AST_LOAD_USE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_branch_taken) &&
         $past(in_ex_mem_read && in_ex_reg_write && (in_ex_rd != '0) &&
               ((in_ex_rd == in_dec_rs1) || (in_ex_rd == in_dec_rs2))))
        |-> (!pc_we && !ifid_we)); // R4

    AST_BUBBLE_PAIR: assert property (@(posedge clk) disable iff (rst)
        bubble_sel == !pc_we); // R5

    AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_branch_taken))
        |-> (flush && pc_we && ifid_we && !bubble_sel)); // R7

    AST_ST_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_mem_mem_write && in_wb_reg_write && in_wb_mem_to_reg &&
                              (in_wb_rd != '0) && (in_mem_rs2 == in_wb_rd)))
        |-> st_data_sel); // R8

    AST_ST_NOSTORE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_mem_mem_write)) |-> !st_data_sel); // R9

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (fwd_a == 2'b00 && fwd_b == 2'b00 && !st_data_sel &&
                        pc_we && ifid_we && !bubble_sel && !flush)); // R10

endmodule

bind hzc_top hzc_checker u_chk (
    .clk              (clk),
    .rst              (rst),
    .in_dec_rs1       (in_dec_rs1),
    .in_dec_rs2       (in_dec_rs2),
    .in_ex_rs1        (in_ex_rs1),
    .in_ex_rs2        (in_ex_rs2),
    .in_ex_rd         (in_ex_rd),
    .in_ex_reg_write  (in_ex_reg_write),
    .in_ex_mem_read   (in_ex_mem_read),
    .in_mem_rd        (in_mem_rd),
    .in_mem_rs2       (in_mem_rs2),
    .in_mem_reg_write (in_mem_reg_write),
    .in_mem_mem_write (in_mem_mem_write),
    .in_wb_rd         (in_wb_rd),
    .in_wb_reg_write  (in_wb_reg_write),
    .in_wb_mem_to_reg (in_wb_mem_to_reg),
    .in_branch_taken  (in_branch_taken),
    .fwd_a            (fwd_a),
    .fwd_b            (fwd_b),
    .st_data_sel      (st_data_sel),
    .pc_we            (pc_we),
    .ifid_we          (ifid_we),
    .bubble_sel       (bubble_sel),
    .flush            (flush)
);

// File: tb/sim_hzc_top.sv
`timescale 1ns/1ps
module sim_hzc_top;

    logic clk = 1'b0;
    logic rst;
    always #2.5 clk = ~clk;

    logic [4:0] dec_rs1, dec_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd;
    logic       ex_rw, ex_mr, mem_rw, mem_mw, wb_rw, wb_mtr, br;
    logic [1:0] fwd_a, fwd_b;
    logic       st_sel, pc_we, ifid_we, bubble, flush;

    hzc_top u0 (
        .clk(clk), .rst(rst),
        .in_dec_rs1(dec_rs1), .in_dec_rs2(dec_rs2),
        .in_ex_rs1(ex_rs1), .in_ex_rs2(ex_rs2), .in_ex_rd(ex_rd),
        .in_ex_reg_write(ex_rw), .in_ex_mem_read(ex_mr),
        .in_mem_rd(mem_rd), .in_mem_rs2(mem_rs2),
        .in_mem_reg_write(mem_rw), .in_mem_mem_write(mem_mw),
        .in_wb_rd(wb_rd), .in_wb_reg_write(wb_rw), .in_wb_mem_to_reg(wb_mtr),
        .in_branch_taken(br),
        .fwd_a(fwd_a), .fwd_b(fwd_b), .st_data_sel(st_sel),
        .pc_we(pc_we), .ifid_we(ifid_we), .bubble_sel(bubble), .flush(flush)
    );

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 1'b0;

    task automatic chk(string req, string scen, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s %s actual=%0d expected=%0d", req, scen, what, act, exp);
        end
    endtask

    function automatic int exp_fwd(logic [4:0] src);
        if (mem_rw && mem_rd != 5'd0 && mem_rd == src) return 2;
        if (wb_rw && wb_rd != 5'd0 && wb_rd == src) return 1;
        return 0;
    endfunction

    function automatic bit exp_stall();
        bit lu;
        lu = ex_mr && ex_rw && ex_rd != 5'd0 && (ex_rd == dec_rs1 || ex_rd == dec_rs2);
        return lu && !br;
    endfunction

    function automatic bit exp_st();
        return mem_mw && wb_rw && wb_mtr && wb_rd != 5'd0 && mem_rs2 == wb_rd;
    endfunction

    task automatic clear_in();
        {dec_rs1, dec_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd} = '0;
        {ex_rw, ex_mr, mem_rw, mem_mw, wb_rw, wb_mtr, br} = '0;
    endtask

    // Called at a falling edge with inputs set; samples at the next falling edge.
    task automatic step_check(string scen, string fwd_req, string st_req, string stall_req);
        int ea, eb, es, est, efl;
        ea  = exp_fwd(ex_rs1);
        eb  = exp_fwd(ex_rs2);
        es  = int'(exp_stall());
        est = int'(exp_st());
        efl = int'(br);
        @(negedge clk);
        chk(fwd_req, scen, "fwd_a", int'(fwd_a), ea);
        chk(fwd_req, scen, "fwd_b", int'(fwd_b), eb);
        chk(st_req, scen, "st_data_sel", int'(st_sel), est);
        chk(stall_req, scen, "pc_we", int'(pc_we), 1 - es);
        chk(stall_req, scen, "ifid_we", int'(ifid_we), 1 - es);
        chk("R5", scen, "bubble_sel", int'(bubble), es);
        chk("R6", scen, "flush", int'(flush), efl);
    endtask

    task automatic check_idle(string scen);
        chk("R10", scen, "fwd_a", int'(fwd_a), 0);
        chk("R10", scen, "fwd_b", int'(fwd_b), 0);
        chk("R10", scen, "st_data_sel", int'(st_sel), 0);
        chk("R10", scen, "pc_we", int'(pc_we), 1);
        chk("R10", scen, "ifid_we", int'(ifid_we), 1);
        chk("R10", scen, "bubble_sel", int'(bubble), 0);
        chk("R10", scen, "flush", int'(flush), 0);
    endtask

    task automatic hazard_vec();
        clear_in();
        ex_rs1 = 5'd3; mem_rd = 5'd3; mem_rw = 1'b1;
        ex_rd = 5'd4; ex_rw = 1'b1; ex_mr = 1'b1; dec_rs1 = 5'd4;
        mem_mw = 1'b1; mem_rs2 = 5'd6; wb_rd = 5'd6; wb_rw = 1'b1; wb_mtr = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        rst = 1'b1;
        hazard_vec();
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_idle("reset with hazard fields held");
        rst = 1'b0;
        clear_in();
        step_check("all quiet", "R1", "R9", "R4");

        // R1: single-source forwards per operand
        clear_in(); ex_rs1 = 5'd5; mem_rd = 5'd5; mem_rw = 1'b1;
        ex_rs2 = 5'd7; wb_rd = 5'd7; wb_rw = 1'b1;
        step_check("R1 mem to A, wb to B", "R1", "R9", "R4");

        // R2: double hazard on both operands
        clear_in(); ex_rs1 = 5'd9; ex_rs2 = 5'd9; mem_rd = 5'd9; mem_rw = 1'b1;
        wb_rd = 5'd9; wb_rw = 1'b1;
        step_check("R2 double hazard", "R2", "R9", "R4");

        // R3: x0 destinations and disabled writes
        clear_in(); mem_rw = 1'b1; wb_rw = 1'b1;
        step_check("R3 x0 destinations", "R3", "R9", "R4");
        clear_in(); ex_rs1 = 5'd2; ex_rs2 = 5'd8; mem_rd = 5'd2; wb_rd = 5'd8;
        step_check("R3 write enables low", "R3", "R9", "R4");
        clear_in(); ex_rd = 5'd0; ex_rw = 1'b1; ex_mr = 1'b1;
        step_check("R3 load to x0 no stall", "R3", "R9", "R4");

        // R4/R5: load-use on each decode source
        clear_in(); ex_rd = 5'd11; ex_rw = 1'b1; ex_mr = 1'b1; dec_rs2 = 5'd11;
        step_check("R4 load-use via rs2", "R1", "R9", "R4");
        clear_in(); ex_rd = 5'd12; ex_rw = 1'b1; ex_mr = 1'b1; dec_rs1 = 5'd12;
        step_check("R5 load-use via rs1", "R1", "R9", "R4");
        clear_in(); ex_rd = 5'd12; ex_rw = 1'b1; ex_mr = 1'b0; dec_rs1 = 5'd12;
        step_check("R4 non-load no stall", "R1", "R9", "R4");

        // R6/R7: branch flush, alone and against a stall
        clear_in(); br = 1'b1;
        step_check("R6 taken branch", "R1", "R9", "R4");
        clear_in(); br = 1'b1; ex_rd = 5'd13; ex_rw = 1'b1; ex_mr = 1'b1; dec_rs1 = 5'd13;
        step_check("R7 flush over stall", "R1", "R9", "R7");

        // R8/R9: store data bypass
        clear_in(); mem_mw = 1'b1; mem_rs2 = 5'd14; wb_rd = 5'd14; wb_rw = 1'b1; wb_mtr = 1'b1;
        step_check("R8 load then store", "R1", "R8", "R4");
        clear_in(); mem_mw = 1'b1; mem_rs2 = 5'd14; wb_rd = 5'd14; wb_rw = 1'b1; wb_mtr = 1'b0;
        step_check("R9 wb not a load", "R1", "R9", "R4");
        clear_in(); mem_mw = 1'b1; wb_rw = 1'b1; wb_mtr = 1'b1;
        step_check("R9 load to x0", "R1", "R9", "R4");
        clear_in(); mem_mw = 1'b0; mem_rs2 = 5'd15; wb_rd = 5'd15; wb_rw = 1'b1; wb_mtr = 1'b1;
        step_check("R9 no store", "R1", "R9", "R4");

        // Random mix on a narrow index range so matches are common
        for (int n = 0; n < 400; n++) begin
            dec_rs1 = 5'($urandom_range(0, 3)); dec_rs2 = 5'($urandom_range(0, 3));
            ex_rs1  = 5'($urandom_range(0, 3)); ex_rs2  = 5'($urandom_range(0, 3));
            ex_rd   = 5'($urandom_range(0, 3)); mem_rd  = 5'($urandom_range(0, 3));
            mem_rs2 = 5'($urandom_range(0, 3)); wb_rd   = 5'($urandom_range(0, 3));
            ex_rw  = 1'($urandom_range(0, 1)); ex_mr  = 1'($urandom_range(0, 1));
            mem_rw = 1'($urandom_range(0, 1)); mem_mw = 1'($urandom_range(0, 1));
            wb_rw  = 1'($urandom_range(0, 1)); wb_mtr = 1'($urandom_range(0, 1));
            br     = ($urandom_range(0, 7) == 0);
            step_check("random", "R1", "R8", "R4");
        end

        // R10: reset in mid-run with every hazard present
        hazard_vec();
        rst = 1'b1;
        @(negedge clk);
        check_idle("mid-run reset");
        rst = 1'b0;
        step_check("after reset release", "R2", "R8", "R4");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule